// File: doc/BRIEF.md
# Leading-Run Weight Compressor

This unit sits in front of a weight-stationary multiply array that stores weights in five bits. It accepts a stream of signed 8-bit two's-complement weights, qualified by a valid bit. For each weight it checks whether the top four bits are all the same. A weight whose top bits form such a run fits in a lossless short form. Any other weight is split. Its upper half goes to the main array, and its low-order remainder goes out as a compensation word for a small side array that corrects the truncation.

In both forms the weight's least significant bit is dropped. The arithmetic downstream treats that bit as an implied 1. A leading flag bit on the 5-bit stored weight tells the array which form it holds.

Every split weight raises a one-cycle write strobe for the compensation store. The strobe comes with a running index, which gives the slot for the word. All outputs are registered, so results appear one clock after the weight is accepted.

Top module: `lead_run_compressor`

## Requirements
- R1: A weight uses the short form when bits [7:4] are all 0 or all 1, and the split form otherwise. Bit 4 of `outWeight` is the form flag: 0 for short, 1 for split.
- R2: In the short form, `outWeight` is {0, w[7], w[3], w[2], w[1]}.
- R3: In the split form, `outWeight` is {1, w[7], w[6], w[5], w[4]}.
- R4: For a split weight, `compWord` is {w[7], w[3], w[2], w[1]}. Bit 3 is the sign of the original weight.
- R5: `compValid` is high for exactly one cycle per accepted split weight. It stays low for short-form weights and for idle cycles.
- R6: `compIdx` is 0 after reset and is presented alongside each compensation word. It advances by one after each word and wraps modulo 32, so the 33rd word after reset carries index 0.
- R7: `outValid` and all results follow the accepted input by exactly one clock. Back-to-back weights give back-to-back results.
- R8: When `inValid` is low, the weight input is ignored. `outValid` and `compValid` go low, and `outWeight`, `compWord` and `compIdx` keep their previous values.
- R9: While reset is asserted, every output reads zero.
- R10: Bit 0 of the weight has no effect on any output. Weights that differ only in bit 0 give identical results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Qualifies `inWeight` in this cycle |
| inWeight | input | 8 | Signed two's-complement weight |
| outValid | output | 1 | A compressed weight is present |
| outWeight | output | 5 | Form flag in bit 4, data field in bits 3:0 |
| compValid | output | 1 | Write strobe for the compensation store |
| compWord | output | 4 | Sign bit plus three remainder bits |
| compIdx | output | 5 | Compensation store slot for `compWord` |

## Verification
Every result of this block, including the weight, the form flag, the compensation word with its strobe, and the index, is due on the rising edge that follows the cycle in which the weight was presented. The bench drives each weight on a falling edge and reads all outputs on the next falling edge. By then exactly one register stage has been crossed. Streaming through the vector table keeps `inValid` high continuously, which tests the back-to-back latency. The idle and wrap checks read the held values and the index one falling edge after their stimulus.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

  typedef struct packed {
    logic loadOut;
    logic splitSel;
    logic loadComp;
  } ctrlStrobe_t;

endpackage

// File: rtl/lrc_ctrl.sv
module lrc_ctrl
  import lrc_pkg::*;
#(
  parameter int W_IN    = 8,
  parameter int RUN_LEN = 4,
  parameter int IDX_W   = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [W_IN-1:0]  inWeight,
  output ctrlStrobe_t      strobe,
  output logic             outValid,
  output logic             compValid,
  output logic [IDX_W-1:0] compIdx
);

  localparam int TOP = W_IN - 1;

  logic [RUN_LEN-1:0] hiBits;
  logic               allZero;
  logic               allOne;
  logic               runFound;
  logic [IDX_W-1:0]   nextIdx;

  assign hiBits   = inWeight[TOP -: RUN_LEN];
  assign allZero  = (hiBits == '0);
  assign allOne   = (hiBits == '1);
  assign runFound = allZero | allOne;

  always_comb begin
    strobe.loadOut  = inValid;
    strobe.splitSel = ~runFound;
    strobe.loadComp = inValid & ~runFound;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      compValid <= 1'b0;
      compIdx   <= '0;
      nextIdx   <= '0;
    end else begin
      outValid  <= strobe.loadOut;
      compValid <= strobe.loadComp;
      if (strobe.loadComp) begin
        compIdx <= nextIdx;
        nextIdx <= nextIdx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lrc_datapath.sv
module lrc_datapath
  import lrc_pkg::*;
#(
  parameter int W_IN        = 8,
  parameter int RUN_LEN     = 4,
  parameter int SIGNED_COMP = 1,
  localparam int STORE_W    = W_IN - RUN_LEN + 1,
  localparam int REM_W      = W_IN - RUN_LEN - 1,
  localparam int COMP_W     = REM_W + SIGNED_COMP
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [W_IN-1:0]    inWeight,
  output logic [STORE_W-1:0] outWeight,
  output logic [COMP_W-1:0]  compWord
);

  localparam int TOP = W_IN - 1;

  logic [REM_W-1:0]   remBits;
  logic [STORE_W-2:0] shortData;
  logic [STORE_W-2:0] splitData;
  logic [STORE_W-1:0] packedWeight;
  logic [COMP_W-1:0]  packedComp;

  assign remBits   = inWeight[REM_W:1];
  assign shortData = {inWeight[TOP], remBits};
  assign splitData = inWeight[TOP -: RUN_LEN];

  assign packedWeight = strobe.splitSel ? {1'b1, splitData} : {1'b0, shortData};

  generate
    if (SIGNED_COMP != 0) begin : g_signed
      assign packedComp = {inWeight[TOP], remBits};
    end else begin : g_unsigned
      assign packedComp = remBits;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outWeight <= '0;
      compWord  <= '0;
    end else begin
      if (strobe.loadOut)  outWeight <= packedWeight;
      if (strobe.loadComp) compWord  <= packedComp;
    end
  end

endmodule

// File: rtl/lead_run_compressor.sv
module lead_run_compressor
  import lrc_pkg::*;
#(
  parameter int W_IN        = 8,
  parameter int RUN_LEN     = 4,
  parameter int SIGNED_COMP = 1,
  parameter int IDX_W       = 5,
  localparam int STORE_W    = W_IN - RUN_LEN + 1,
  localparam int COMP_W     = W_IN - RUN_LEN - 1 + SIGNED_COMP
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [W_IN-1:0]    inWeight,
  output logic               outValid,
  output logic [STORE_W-1:0] outWeight,
  output logic               compValid,
  output logic [COMP_W-1:0]  compWord,
  output logic [IDX_W-1:0]   compIdx
);

  ctrlStrobe_t strobe;

  lrc_ctrl #(
    .W_IN(W_IN), .RUN_LEN(RUN_LEN), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWeight(inWeight),
    .strobe(strobe), .outValid(outValid), .compValid(compValid),
    .compIdx(compIdx)
  );

  lrc_datapath #(
    .W_IN(W_IN), .RUN_LEN(RUN_LEN), .SIGNED_COMP(SIGNED_COMP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inWeight(inWeight),
    .outWeight(outWeight), .compWord(compWord)
  );

endmodule

// File: rtl/lrc_checker.sv
module lrc_checker #(
  parameter int W_IN        = 8,
  parameter int RUN_LEN     = 4,
  parameter int SIGNED_COMP = 1,
  parameter int IDX_W       = 5,
  localparam int STORE_W    = W_IN - RUN_LEN + 1,
  localparam int COMP_W     = W_IN - RUN_LEN - 1 + SIGNED_COMP
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [W_IN-1:0]    inWeight,
  input logic               outValid,
  input logic [STORE_W-1:0] outWeight,
  input logic               compValid,
  input logic [COMP_W-1:0]  compWord,
  input logic [IDX_W-1:0]   compIdx
);

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  a_r8_idle_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && !compValid));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outWeight) && $stable(compWord) && $stable(compIdx)));

  a_r5_comp_only_split: assert property (@(posedge clk) disable iff (!rstN)
    compValid |-> (outValid && outWeight[STORE_W-1]));

  a_r5_short_no_comp: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outWeight[STORE_W-1]) |-> !compValid);

  a_r6_idx_advance: assert property (@(posedge clk) disable iff (!rstN)
    (compValid && $past(compValid)) |-> (compIdx == IDX_W'($past(compIdx) + 1'b1)));

  a_r6_idx_hold: assert property (@(posedge clk) disable iff (!rstN)
    !compValid |=> (!compValid || compIdx == IDX_W'($past(compIdx) + 1'b1) || $past(compIdx) == compIdx));

  generate
    if (SIGNED_COMP != 0) begin : g_sign
      a_r4_sign_match: assert property (@(posedge clk) disable iff (!rstN)
        compValid |-> (compWord[COMP_W-1] == outWeight[STORE_W-2]));
    end
  endgenerate

endmodule

bind lead_run_compressor lrc_checker #(
  .W_IN(W_IN), .RUN_LEN(RUN_LEN), .SIGNED_COMP(SIGNED_COMP), .IDX_W(IDX_W)
) u_lrc_checker (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inWeight(inWeight),
  .outValid(outValid), .outWeight(outWeight), .compValid(compValid),
  .compWord(compWord), .compIdx(compIdx)
);

// File: tb/lead_run_compressor_test.sv
module lead_run_compressor_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic       inValid;
  logic [7:0] inWeight;
  logic       outValid;
  logic [4:0] outWeight;
  logic       compValid;
  logic [3:0] compWord;
  logic [4:0] compIdx;

  int checks   = 0;
  int failures = 0;

  always #5 clk = ~clk;

  lead_run_compressor uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWeight(inWeight),
    .outValid(outValid), .outWeight(outWeight), .compValid(compValid),
    .compWord(compWord), .compIdx(compIdx)
  );

  // {weight, expected outWeight, split flag, expected compWord}
  localparam logic [17:0] VEC [0:11] = '{
    {8'h0D, 5'h06, 1'b0, 4'h0},  // R2 positive short
    {8'hF6, 5'h0B, 1'b0, 4'h0},  // R2 negative short
    {8'h0C, 5'h06, 1'b0, 4'h0},  // R10 bit0 differs from 0x0D
    {8'h7F, 5'h17, 1'b1, 4'h7},  // R3 R4
    {8'h80, 5'h18, 1'b1, 4'h8},  // R3 R4 most negative
    {8'hA5, 5'h1A, 1'b1, 4'hA},  // R3 R4
    {8'h00, 5'h00, 1'b0, 4'h0},  // R1 all zero
    {8'hFF, 5'h0F, 1'b0, 4'h0},  // R1 all one
    {8'h10, 5'h11, 1'b1, 4'h0},  // R1 just outside run
    {8'hEF, 5'h1E, 1'b1, 4'hF},  // R1 R4 negative split
    {8'h3B, 5'h13, 1'b1, 4'h5},  // R3 R4
    {8'hF1, 5'h08, 1'b0, 4'h0}   // R2
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int expIdx;
    rstN = 1'b0; inValid = 1'b0; inWeight = 8'h00;
    repeat (2) @(negedge clk);
    // R9 reset state
    chk("R9 outValid", 32'(outValid), 32'd0);
    chk("R9 compValid", 32'(compValid), 32'd0);
    chk("R9 outWeight", 32'(outWeight), 32'd0);
    chk("R9 compWord", 32'(compWord), 32'd0);
    chk("R9 compIdx", 32'(compIdx), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Table walk, back-to-back (R1 R2 R3 R4 R5 R7 R10)
    expIdx = 0;
    for (int i = 0; i < 12; i++) begin
      inValid  = 1'b1;
      inWeight = VEC[i][17:10];
      @(negedge clk);
      chk("R7 outValid", 32'(outValid), 32'd1);
      chk("R1 R2 R3 outWeight", 32'(outWeight), 32'(VEC[i][9:5]));
      chk("R5 compValid", 32'(compValid), 32'(VEC[i][4]));
      if (VEC[i][4]) begin
        chk("R4 compWord", 32'(compWord), 32'(VEC[i][3:0]));
        chk("R6 compIdx", 32'(compIdx), 32'(expIdx));
        expIdx++;
      end
    end

    // R8 idle: a split pattern on the input must be ignored
    inValid  = 1'b0;
    inWeight = 8'h7F;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk("R8 outValid", 32'(outValid), 32'd0);
      chk("R8 compValid", 32'(compValid), 32'd0);
      chk("R8 outWeight", 32'(outWeight), 32'h08);
      chk("R8 compWord", 32'(compWord), 32'h5);
      chk("R8 compIdx", 32'(compIdx), 32'(expIdx - 1));
    end

    // R6 wrap after a fresh reset
    rstN = 1'b0;
    @(negedge clk);
    chk("R9 compIdx after reset", 32'(compIdx), 32'd0);
    rstN = 1'b1;
    for (int k = 0; k < 33; k++) begin
      inValid  = 1'b1;
      inWeight = 8'h80;
      @(negedge clk);
      chk("R6 wrap compIdx", 32'(compIdx), 32'(k % 32));
      chk("R5 wrap compValid", 32'(compValid), 32'd1);
    end
    inValid = 1'b0;
    @(negedge clk);
    chk("R7 outValid drop", 32'(outValid), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule